// File: doc/BRIEF.md
# SMBus Byte-Data Register Master

This block is a bus master for single-register accesses on an SMBus or I2C segment. A host programs it through eight byte-wide registers: the 7-bit target address, the command byte that picks the register inside the target, and, for a write, the data byte. A write to the control register then starts one transfer. A write-byte transfer sends START, the address with the write bit, the command, the data and STOP. A read-byte transfer sends START, the address with the write bit and the command, then a repeated START, the address with the read bit, receives one byte, answers it with a NACK and sends STOP.

Outcomes go to a write-1-to-clear status register: write finished, read finished, or target did not acknowledge. The same register also holds a level from an external client interrupt line. A mask register selects which status bits reach the single level interrupt output. SCL and SDA are open-drain: the block only ever pulls a line low. SCL timing comes from a quarter-period counter derived from two clock-frequency parameters. The block does not support clock stretching, arbitration or multi-byte transfers.

The host port is a plain register strobe, not a stream. A write is taken in the cycle `reg_wr` is high. Read data is combinational from `reg_addr`. There is no back-pressure: while a transfer runs, the control register is the only register whose writes are dropped.

Top module: `smbus_byte_master`

## Requirements
- R1: Register offsets are fixed. Control is 0, target address 1 (bits 6:0), command 2, write data 3, read data 4, status 6 and mask 7. Offset 5 and the control register read as 0. After reset, status is 0x00, mask is 0xF1 and both bus lines are released.
- R2: Writing control bit 0 while idle runs a write transfer: START, byte {addr,0}, command, data, STOP. Each byte is followed by an acknowledge clock. On success, status bit 1 is set.
- R3: Writing control bit 1 (with bit 0 clear) while idle runs a read transfer: START, {addr,0}, command, repeated START, {addr,1}, one received byte, master NACK, STOP. The received byte is in the read-data register no later than the cycle in which status bit 2 is set.
- R4: If a target leaves SDA high in any acknowledge slot of a sent byte, the block goes straight to STOP. It then sets only status bit 3; bits 1 and 2 stay clear.
- R5: Control writes made during a transfer start nothing: exactly one START/STOP pair follows, and no second transfer comes afterwards. When both start bits are written as 1, a write transfer runs.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a set event and a clear fall in the same cycle, the bit stays set.
- R7: While the client interrupt input is high, status bit 0 is set again every cycle; this includes the cycle right after a clear.
- R8: `irq_o` is high exactly when some status bit 3:0 is set and its mask bit is 0.
- R9: Each SCL clock period is 4*(CLK_HZ/(4*SCL_HZ)) system cycles. Inside a byte, SDA changes only while SCL is low. The only SDA edges with SCL high are the START, repeated START and STOP conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| client_irq_i | input | 1 | Client interrupt level, asynchronous |
| irq_o | output | 1 | Level interrupt to host |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | SDA line level, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions assume that SDA is driven only at its open-drain level: the target changes it while SCL is low, and only inside a transfer. They also assume the host does not depend on write-data or address changes made mid-transfer, since these are captured at start. The bench target model changes SDA only on a falling SCL edge that it has seen. It drives SDA low only for acknowledges or read data. The host only writes control during a transfer, and only to test that such writes are dropped. A sweep of eight command/data pairs, plus one untouched location, checks the read-after-write arithmetic against a pattern computed in the bench.

// File: rtl/smbm_pkg.sv
package smbm_pkg;
  typedef enum logic [1:0] {OP_START, OP_TX, OP_RX, OP_STOP} smbm_op_e;

  localparam logic [2:0] OFS_CTRL  = 3'd0;
  localparam logic [2:0] OFS_TADDR = 3'd1;
  localparam logic [2:0] OFS_CMD   = 3'd2;
  localparam logic [2:0] OFS_WDATA = 3'd3;
  localparam logic [2:0] OFS_RDATA = 3'd4;
  localparam logic [2:0] OFS_STAT  = 3'd6;
  localparam logic [2:0] OFS_MASK  = 3'd7;

  localparam int ST_CLIENT = 0;
  localparam int ST_WDONE  = 1;
  localparam int ST_RDONE  = 2;
  localparam int ST_NACK   = 3;
  localparam logic [7:0] MASK_RST = 8'hF1;
endpackage

// File: rtl/smbm_tick.sv
module smbm_tick #(
  parameter int QTR_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);

  generate
    if (QTR_CYC > 1) begin : g_spacing
      // R9
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/smbm_engine.sv
module smbm_engine
  import smbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic       read_i,
  input  logic [6:0] taddr_i,
  input  logic [7:0] cmd_i,
  input  logic [7:0] wdata_i,
  input  logic       sda_in,
  output logic       busy_o,
  output logic       fin_o,
  output logic       fin_nack_o,
  output logic       fin_read_o,
  output logic       rx_valid_o,
  output logic [7:0] rx_byte_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  logic [2:0] step_q;
  logic [1:0] ph_q;
  logic [3:0] bit_q;
  logic       rd_q, nack_q, nack_seen_q;
  logic [6:0] addr_q;
  logic [7:0] cmd_q, wd_q, sh_q;
  smbm_op_e   op;
  logic [7:0] txb;
  logic [2:0] stop_step;

  always_comb begin
    txb = 8'h00;
    case (step_q)
      3'd0: op = OP_START;
      3'd1: begin op = OP_TX; txb = {addr_q, 1'b0}; end
      3'd2: begin op = OP_TX; txb = cmd_q; end
      3'd3: begin
        if (rd_q) op = OP_START;
        else begin op = OP_TX; txb = wd_q; end
      end
      3'd4: begin
        if (rd_q) begin op = OP_TX; txb = {addr_q, 1'b1}; end
        else op = OP_STOP;
      end
      3'd5: op = OP_RX;
      default: op = OP_STOP;
    endcase
  end

  assign stop_step = rd_q ? 3'd6 : 3'd4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0; fin_o <= 1'b0; rx_valid_o <= 1'b0;
      step_q <= '0; ph_q <= '0; bit_q <= '0;
      rd_q <= 1'b0; nack_q <= 1'b0; nack_seen_q <= 1'b0;
      addr_q <= '0; cmd_q <= '0; wd_q <= '0; sh_q <= '0; rx_byte_o <= '0;
    end else begin
      fin_o      <= 1'b0;
      rx_valid_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1; step_q <= '0; ph_q <= '0; bit_q <= '0;
          nack_seen_q <= 1'b0; nack_q <= 1'b0;
          rd_q <= read_i; addr_q <= taddr_i; cmd_q <= cmd_i; wd_q <= wdata_i;
        end
      end else if (tick_i) begin
        ph_q <= ph_q + 1'b1;
        case (op)
          OP_START: if (ph_q == 2'd3) step_q <= step_q + 1'b1;
          OP_STOP: if (ph_q == 2'd3) begin
            busy_o <= 1'b0;
            fin_o  <= 1'b1;
          end
          default: begin
            if (ph_q == 2'd2) begin
              if (op == OP_RX && bit_q < 4'd8) sh_q <= {sh_q[6:0], sda_in};
              if (op == OP_TX && bit_q == 4'd8) nack_q <= sda_in;
            end
            if (ph_q == 2'd3) begin
              if (bit_q == 4'd8) begin
                bit_q <= '0;
                if (op == OP_TX && nack_q) begin
                  step_q      <= stop_step;
                  nack_seen_q <= 1'b1;
                end else begin
                  step_q <= step_q + 1'b1;
                end
                if (op == OP_RX) begin
                  rx_valid_o <= 1'b1;
                  rx_byte_o  <= sh_q;
                end
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  assign fin_nack_o = nack_seen_q;
  assign fin_read_o = rd_q;

  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    if (busy_o) begin
      case (op)
        OP_START: begin
          scl_oe_o = (ph_q == 2'd0) ? (step_q != 3'd0) : (ph_q == 2'd3);
          sda_oe_o = (ph_q >= 2'd2);
        end
        OP_TX: begin
          scl_oe_o = (ph_q == 2'd0) || (ph_q == 2'd3);
          sda_oe_o = (bit_q < 4'd8) && !txb[3'd7 - bit_q[2:0]];
        end
        OP_RX: scl_oe_o = (ph_q == 2'd0) || (ph_q == 2'd3);
        default: begin
          scl_oe_o = (ph_q == 2'd0);
          sda_oe_o = (ph_q <= 2'd1);
        end
      endcase
    end
  end

  // R9
  sda_in_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (op == OP_TX || op == OP_RX) && !$stable(sda_oe_o))
      |-> (scl_oe_o && $past(scl_oe_o)));

  // R4
  nack_to_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && tick_i && op == OP_TX && bit_q == 4'd8 && ph_q == 2'd3 && nack_q)
      |=> (op == OP_STOP && fin_nack_o));

  // R2
  fin_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: rtl/smbus_byte_master.sv
module smbus_byte_master
  import smbm_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int SCL_HZ = 100_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       client_irq_i,
  output logic       irq_o,
  output logic       scl_oe,
  input  logic       sda_i,
  output logic       sda_oe
);
  localparam int QTR_CYC = CLK_HZ / (4 * SCL_HZ);
  localparam int SYNC_N  = 2;

  logic [SYNC_N-1:0] sda_sync_q, cli_sync_q;
  logic [6:0] taddr_q;
  logic [7:0] cmd_q, wd_q, rd_q, mask_q;
  logic [3:0] stat_q, ev, clr;
  logic eng_busy, eng_fin, eng_nack, eng_read, rx_valid, tick;
  logic [7:0] rx_byte;
  logic ctrl_wr, go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_sync_q <= '1;
      cli_sync_q <= '0;
    end else begin
      sda_sync_q <= {sda_sync_q[SYNC_N-2:0], sda_i};
      cli_sync_q <= {cli_sync_q[SYNC_N-2:0], client_irq_i};
    end
  end

  assign ctrl_wr = reg_wr && reg_addr == OFS_CTRL;
  assign go      = ctrl_wr && !eng_busy && (reg_wdata[0] || reg_wdata[1]);

  smbm_tick #(.QTR_CYC(QTR_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .en_i(eng_busy), .tick_o(tick));

  smbm_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(go),
    .read_i(!reg_wdata[0]), .taddr_i(taddr_q), .cmd_i(cmd_q), .wdata_i(wd_q),
    .sda_in(sda_sync_q[SYNC_N-1]), .busy_o(eng_busy), .fin_o(eng_fin),
    .fin_nack_o(eng_nack), .fin_read_o(eng_read), .rx_valid_o(rx_valid),
    .rx_byte_o(rx_byte), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe));

  always_comb begin
    ev = '0;
    ev[ST_CLIENT] = cli_sync_q[SYNC_N-1];
    ev[ST_WDONE]  = eng_fin && !eng_nack && !eng_read;
    ev[ST_RDONE]  = eng_fin && !eng_nack && eng_read;
    ev[ST_NACK]   = eng_fin && eng_nack;
    clr = (reg_wr && reg_addr == OFS_STAT) ? reg_wdata[3:0] : 4'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taddr_q <= '0; cmd_q <= '0; wd_q <= '0; rd_q <= '0;
      mask_q <= MASK_RST; stat_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | ev;
      if (rx_valid) rd_q <= rx_byte;
      if (reg_wr) begin
        case (reg_addr)
          OFS_TADDR: taddr_q <= reg_wdata[6:0];
          OFS_CMD:   cmd_q   <= reg_wdata;
          OFS_WDATA: wd_q    <= reg_wdata;
          OFS_MASK:  mask_q  <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_TADDR: reg_rdata = {1'b0, taddr_q};
      OFS_CMD:   reg_rdata = cmd_q;
      OFS_WDATA: reg_rdata = wd_q;
      OFS_RDATA: reg_rdata = rd_q;
      OFS_STAT:  reg_rdata = {4'h0, stat_q};
      OFS_MASK:  reg_rdata = mask_q;
      default:   reg_rdata = 8'h00;
    endcase
  end

  assign irq_o = |(stat_q & ~mask_q[3:0]);

  generate
    for (genvar b = 0; b < 4; b++) begin : g_stat_chk
      // R6
      stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[b] && !(reg_wr && reg_addr == OFS_STAT && reg_wdata[b])) |=> stat_q[b]);
    end
  endgenerate

  // R3
  rdata_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[ST_RDONE]) |-> ($stable(rd_q) && !rx_valid));

  // R7
  client_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cli_sync_q[SYNC_N-1] |=> stat_q[ST_CLIENT]);

  // R5
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && ctrl_wr) |=> eng_busy);
endmodule

// File: tb/test_smbus_byte_master.sv
module test_smbus_byte_master;
  localparam int TGT = 7'h6B;
  localparam int BITP = 12;

  logic clk = 0, rst_n = 0, reg_wr = 0, client = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq_o, scl_oe, sda_oe, scl, sda;
  logic tgt_low = 0;
  int checks = 0, fails = 0, cyc = 0;
  int n_start = 0, n_stop = 0, last_rise = 0, per = 0;
  logic [7:0] mem [256];

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  assign scl = !scl_oe;
  assign sda = !(sda_oe || tgt_low);

  smbus_byte_master #(.CLK_HZ(1_200_000), .SCL_HZ(100_000)) i_smbus_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .client_irq_i(client),
    .irq_o(irq_o), .scl_oe(scl_oe), .sda_i(sda), .sda_oe(sda_oe));

  // target model: 0 none, 1 addr, 2 cmd, 3 wdata, 4 rdata
  int st = 0, bc = 0, rb = 0;
  logic ackph = 0, pscl = 1, psda = 1;
  logic [7:0] sh = 0, ptr = 0, ob = 0;
  always @(negedge clk) begin
    if (scl && pscl && psda && !sda) begin
      n_start++; st = 1; bc = 0; ackph = 0; tgt_low = 0;
    end else if (scl && pscl && !psda && sda) begin
      n_stop++; st = 0; tgt_low = 0;
    end else if (scl && !pscl) begin
      if (last_rise != 0) per = cyc - last_rise;
      last_rise = cyc;
      if (st == 4) rb++;
      else if (st != 0 && !ackph) begin sh = {sh[6:0], sda}; bc++; end
    end else if (!scl && pscl) begin
      if (st == 4) begin
        if (rb < 8) tgt_low = !ob[7-rb]; else tgt_low = 0;
        if (rb >= 9) st = 0;
      end else if (st != 0 && bc == 8 && !ackph) begin
        if (st == 1 && sh[7:1] != TGT) st = 0;
        else begin tgt_low = 1; ackph = 1; end
      end else if (ackph) begin
        tgt_low = 0; ackph = 0; bc = 0;
        if (st == 1) begin
          if (sh[0]) begin st = 4; rb = 0; ob = mem[ptr]; tgt_low = !ob[7]; end
          else st = 2;
        end else if (st == 2) begin ptr = sh; st = 3; end
        else if (st == 3) begin mem[ptr] = sh; ptr++; end
      end
    end
    pscl = scl; psda = sda;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq_o && n < 5000) begin @(negedge clk); n++; end
    check(irq_o, req, 0, 1);
    repeat (4) @(negedge clk);
  endtask

  logic [7:0] v;
  int s0, p0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk); rst_n = 1;
    // R1 reset state
    rd(7, v); check(v == 8'hF1, "R1 mask reset", v, 8'hF1);
    rd(6, v); check(v == 0, "R1 status reset", v, 0);
    check(!irq_o && scl && sda, "R1 idle pins", {irq_o, scl, sda}, 3'b011);
    wr(1, 8'(TGT)); rd(1, v); check(v == 8'(TGT), "R1 taddr readback", v, TGT);
    rd(5, v); check(v == 0, "R1 offset5 zero", v, 0);

    for (int i = 0; i < 8; i++) begin
      logic [7:0] c, d;
      c = 8'(i * 37 + 5); d = 8'(i * 91 + 17);
      wr(2, c); wr(3, d);
      s0 = n_start; p0 = n_stop;
      wr(0, 8'h01); wait_irq("R2 write irq");
      rd(6, v); check(v == 8'h02, "R2 write status", v, 2);
      check(mem[c] == d, "R2 target memory", mem[c], d);
      check(n_start - s0 == 1 && n_stop - p0 == 1, "R9 write start/stop",
            n_start - s0, 1);
      check(per == BITP, "R9 scl period", per, BITP);
      rd(0, v); check(v == 0, "R5 ctrl self-clear", v, 0);
      wr(6, 8'h02); rd(6, v); check(v == 0, "R6 w1c", v, 0);
      check(!irq_o, "R8 irq drops", irq_o, 0);
      s0 = n_start;
      wr(0, 8'h02); wait_irq("R3 read irq");
      rd(6, v); check(v == 8'h04, "R3 read status", v, 4);
      rd(4, v); check(v == d, "R3 read data", v, d);
      check(n_start - s0 == 2, "R9 repeated start", n_start - s0, 2);
      wr(6, 8'h04);
    end

    // R3 untouched location
    wr(2, 8'hC8); wr(0, 8'h02); wait_irq("R3 read irq2");
    rd(4, v); check(v == 8'(8'hC8 * 7 + 3), "R3 pattern read", v, 8'(8'hC8 * 7 + 3));
    wr(6, 8'h0F);

    // R5 control writes while busy ignored
    wr(2, 8'h40); wr(3, 8'h99);
    s0 = n_start; p0 = n_stop;
    wr(0, 8'h01); repeat (20) @(negedge clk); wr(0, 8'h02);
    wait_irq("R5 busy irq");
    repeat (400) @(negedge clk);
    rd(6, v); check(v == 8'h02, "R5 busy ctrl ignored", v, 2);
    check(n_start - s0 == 1 && n_stop - p0 == 1, "R5 single transfer", n_start - s0, 1);
    wr(6, 8'h0F);
    // R5 both bits -> write
    wr(3, 8'h5A); wr(0, 8'h03); wait_irq("R5 both irq");
    rd(6, v); check(v == 8'h02, "R5 both bits write", v, 2);
    check(mem[8'h40] == 8'h5A, "R5 both bits data", mem[8'h40], 8'h5A);
    wr(6, 8'h0F);

    // R4 NACK on address
    wr(1, 8'h22); s0 = n_start; p0 = n_stop;
    wr(0, 8'h02); wait_irq("R4 nack irq");
    rd(6, v); check(v == 8'h08, "R4 nack status", v, 8);
    check(n_start - s0 == 1 && n_stop - p0 == 1, "R4 abort stop", n_stop - p0, 1);
    wr(6, 8'h08); wr(1, 8'(TGT));

    // R8 mask suppresses done
    wr(7, 8'hF3); wr(0, 8'h01); repeat (1500) @(negedge clk);
    rd(6, v); check(v == 8'h02, "R8 masked status", v, 2);
    check(!irq_o, "R8 masked irq low", irq_o, 0);
    wr(7, 8'hF1); @(negedge clk); check(irq_o, "R8 unmask irq", irq_o, 1);
    wr(6, 8'h02);

    // R7 client input
    client = 1; repeat (4) @(negedge clk);
    rd(6, v); check(v == 8'h01, "R7 client status", v, 1);
    check(!irq_o, "R8 client masked", irq_o, 0);
    wr(7, 8'hF0); @(negedge clk); check(irq_o, "R8 client unmasked", irq_o, 1);
    wr(6, 8'h01); rd(6, v); check(v == 8'h01, "R7 level re-sets", v, 1);
    client = 0; repeat (4) @(negedge clk);
    wr(6, 8'h01); rd(6, v); check(v == 0, "R6 client cleared", v, 0);
    check(!irq_o, "R8 irq clear", irq_o, 0);
    wr(7, 8'hF1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule